// File: doc/BRIEF.md
# Dual-PWM FSK Tone Generator

This block turns a serial bit stream into binary frequency-shift-keyed carrier tones for a line-driver front end. It drives two center-aligned PWM outputs at a common carrier frequency. The wide output is high for about two thirds of each carrier period. The narrow output is high for about one third, centred inside the wide pulse. An external analog summing low-pass filter adds the two into a three-level stepped waveform that approximates one sine cycle per carrier period.

Bits arrive one at a time over a valid/ready handshake. Each bit selects one of two tones, and a parameter sets which bit value selects which tone. A bit lasts a fixed number of system clocks. A tone change waits for the carrier counter to return to zero, so every carrier period is complete. When the stream runs dry, or when transmit enable is low, both outputs go low and the block reports idle.

Top module: `fsk_dualpwm_tx`

## Requirements
- R1: While reset is asserted, and right after it is released, `pwm_wide`, `pwm_narrow` and `busy` are low.
- R2: Each tone uses a half-period count H = round(CLK_HZ / (2 * tone_hz)). Its carrier period is 2*H clocks: an up-down count 0 to H and back. With the default parameters, tone 0 (63 kHz) gives 1588 clocks and tone 1 (74 kHz) gives 1352 clocks.
- R3: `pwm_wide` is high while the count is at or above floor(H/3). Its first rising edge comes floor(H/3) clocks after the bit is accepted, and each pulse lasts 2*(H - floor(H/3)) + 1 clocks.
- R4: `pwm_narrow` is high while the count is at or above floor(2H/3), so each pulse lasts 2*(H - floor(2H/3)) + 1 clocks. It is never high while `pwm_wide` is low. Its rising edge comes floor(2H/3) - floor(H/3) clocks after the `pwm_wide` rise in the same period.
- R5: With MARK_TONE1 = 1, bit value 1 selects tone 1 and bit value 0 selects tone 0. With MARK_TONE1 = 0 the mapping is reversed.
- R6: A bit is accepted at a clock edge where `bit_valid` and `bit_ready` are both high. `bit_ready` is high while enabled and idle. While a bit is active, `bit_ready` is high only in the last of its BIT_CLKS clocks.
- R7: A new tone takes effect only when the carrier count is zero. A tone change therefore never shortens a carrier period: the spacing between `pwm_wide` rises across a change equals 2*H_old - floor(H_old/3) + floor(H_new/3).
- R8: If no bit is offered when a bit ends, then from the next clock `busy`, `pwm_wide` and `pwm_narrow` are low.
- R9: While `tx_en` is low, `bit_ready` is low. From the next clock `busy` and both outputs are low and the count is held at zero, so the next accepted bit starts a fresh carrier period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmit enable |
| bit_valid | input | 1 | Next bit is offered |
| bit_data | input | 1 | Value of the offered bit |
| bit_ready | output | 1 | Block takes the offered bit at this edge |
| pwm_wide | output | 1 | Two-thirds-duty carrier PWM |
| pwm_narrow | output | 1 | One-third-duty carrier PWM, centred in the wide pulse |
| busy | output | 1 | A bit is being transmitted |

## Verification
The bench checks tone changes in both directions, with a bit length that is not a multiple of either carrier period, so each change has to wait for the count to reach zero. A design that switched at the bit boundary would produce a shortened carrier period and a wrong rise spacing. A design that switched one period late would show an extra old-tone pulse.

Several other corner cases are covered:
- Pulse widths and the offset of the narrow pulse, to catch off-by-one compare thresholds and turn-around points.
- Bit length, measured through the `bit_ready` timing, which catches a wrong bit counter.
- Restart after disable, which exposes a counter that resumes from where it stopped instead of from zero.
- A default-parameter instance with the reversed bit mapping. It confirms that the half-period counts are rounded and not truncated, which would change the measured periods by two clocks.

// File: rtl/fsk_dualpwm_tx.sv
module fsk_dualpwm_tx #(
  parameter int CLK_HZ     = 100_000_000,
  parameter int TONE0_HZ   = 63_000,
  parameter int TONE1_HZ   = 74_000,
  parameter int BIT_CLKS   = 4000,
  parameter int MARK_TONE1 = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en,
  input  logic bit_valid,
  input  logic bit_data,
  output logic bit_ready,
  output logic pwm_wide,
  output logic pwm_narrow,
  output logic busy
);
  localparam int H0   = (CLK_HZ + TONE0_HZ) / (2 * TONE0_HZ);
  localparam int H1   = (CLK_HZ + TONE1_HZ) / (2 * TONE1_HZ);
  localparam int HMAX = (H0 > H1) ? H0 : H1;
  localparam int CW   = $clog2(HMAX + 1);
  localparam int BW   = (BIT_CLKS > 1) ? $clog2(BIT_CLKS) : 1;

  localparam logic [CW-1:0] HALF0 = CW'(H0);
  localparam logic [CW-1:0] HALF1 = CW'(H1);
  localparam logic [CW-1:0] LO0   = CW'(H0 / 3);
  localparam logic [CW-1:0] HI0   = CW'((2 * H0) / 3);
  localparam logic [CW-1:0] LO1   = CW'(H1 / 3);
  localparam logic [CW-1:0] HI1   = CW'((2 * H1) / 3);
  localparam logic [BW-1:0] BLAST = BW'(BIT_CLKS - 1);

  logic          active, up, cur_sel, nxt_sel;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bit_cnt;

  wire [CW-1:0] half  = cur_sel ? HALF1 : HALF0;
  wire [CW-1:0] lo_th = cur_sel ? LO1 : LO0;
  wire [CW-1:0] hi_th = cur_sel ? HI1 : HI0;

  wire bit_last = (bit_cnt == BLAST);
  wire take     = bit_valid && bit_ready;
  wire take_sel = (MARK_TONE1 != 0) ? bit_data : !bit_data;

  assign bit_ready  = tx_en && (!active || bit_last);
  assign busy       = active;
  assign pwm_wide   = active && (cnt >= lo_th);
  assign pwm_narrow = active && (cnt >= hi_th);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      up      <= 1'b1;
      cnt     <= '0;
      bit_cnt <= '0;
      cur_sel <= 1'b0;
      nxt_sel <= 1'b0;
    end else if (!tx_en) begin
      active  <= 1'b0;
      up      <= 1'b1;
      cnt     <= '0;
      bit_cnt <= '0;
    end else begin
      if (take) begin
        active  <= 1'b1;
        bit_cnt <= '0;
        nxt_sel <= take_sel;
      end else if (active) begin
        if (bit_last) begin
          active  <= 1'b0;
          bit_cnt <= '0;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end

      if ((active || take) && cnt == '0)
        cur_sel <= take ? take_sel : nxt_sel;

      if (active && (take || !bit_last)) begin
        if (up) begin
          cnt <= cnt + 1'b1;
          if (cnt == half - 1'b1) up <= 1'b0;
        end else begin
          cnt <= cnt - 1'b1;
          if (cnt == CW'(1)) up <= 1'b1;
        end
      end else begin
        cnt <= '0;
        up  <= 1'b1;
      end
    end
  end

  assert_nested_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_narrow |-> pwm_wide);

  assert_cnt_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= half);

  assert_tone_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (active && cnt != '0) |=> $stable(cur_sel));

  assert_bit_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= BLAST);

  assert_drain_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && active && bit_last && !bit_valid) |=> (!busy && !pwm_wide));

  assert_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> (!busy && cnt == '0 && !pwm_wide && !pwm_narrow));
endmodule

// File: tb/sim_fsk_dualpwm_tx.sv
module sim_fsk_dualpwm_tx;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_en = 1'b0, valid = 1'b0, data = 1'b0;
  logic ready, pw, pn, busy;
  logic v1 = 1'b0, d1 = 1'b0;
  logic rdy1, pw1, pn1, busy1;
  int total = 0, fails = 0, cyc = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc = cyc + 1;

  fsk_dualpwm_tx #(.CLK_HZ(1_200_000), .TONE0_HZ(50_000), .TONE1_HZ(100_000),
                   .BIT_CLKS(30), .MARK_TONE1(1)) u0 (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .bit_valid(valid), .bit_data(data),
    .bit_ready(ready), .pwm_wide(pw), .pwm_narrow(pn), .busy(busy));

  fsk_dualpwm_tx #(.MARK_TONE1(0)) u1 (
    .clk(clk), .rst_n(rst_n), .tx_en(1'b1), .bit_valid(v1), .bit_data(d1),
    .bit_ready(rdy1), .pwm_wide(pw1), .pwm_narrow(pn1), .busy(busy1));

  int r1[16], w1[16], r2[16], w2[16];
  int n1 = 0, m1 = 0, n2 = 0, m2 = 0, len1 = 0, len2 = 0;
  logic p1 = 1'b0, p2 = 1'b0;

  always @(negedge clk) begin
    if (pw && !p1 && n1 < 16) begin r1[n1] = cyc; n1 = n1 + 1; end
    if (pw) len1 = len1 + 1;
    else begin if (p1 && m1 < 16) begin w1[m1] = len1; m1 = m1 + 1; end len1 = 0; end
    p1 = pw;
    if (pn && !p2 && n2 < 16) begin r2[n2] = cyc; n2 = n2 + 1; end
    if (pn) len2 = len2 + 1;
    else begin if (p2 && m2 < 16) begin w2[m2] = len2; m2 = m2 + 1; end len2 = 0; end
    p2 = pn;
  end

  task automatic clr();
    n1 = 0; m1 = 0; n2 = 0; m2 = 0;
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    total = total + 1;
    if (act != exp) begin
      fails = fails + 1;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic send(input int n, input logic [7:0] b, output int acc);
    acc = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); valid = 1'b1; data = b[i];
      #1;
      while (!ready) begin @(negedge clk); #1; end
      @(posedge clk); #1;
      if (i == 0) acc = cyc;
    end
    @(negedge clk); valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "wide in reset", int'(pw), 0);
    chk("R1", "busy in reset", int'(busy), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); tx_en = 1'b1;
    @(negedge clk);
    chk("R1", "wide after reset", int'(pw), 0);
    chk("R1", "narrow after reset", int'(pn), 0);
    chk("R6", "ready when idle", int'(ready), 1);
  endtask

  task automatic t_slow_to_fast();
    int acc;
    clr();
    send(2, 8'b10, acc);
    repeat (70) @(negedge clk);
    chk("R3", "first wide rise offset", r1[0] - acc, 4);
    chk("R2", "tone0 period", r1[1] - r1[0], 24);
    chk("R7", "spacing across 0->1 change", r1[2] - r1[1], 22);
    chk("R7", "wide pulse count", n1, 3);
    chk("R3", "tone0 wide width", w1[0], 17);
    chk("R3", "tone1 wide width", w1[2], 9);
    chk("R4", "tone0 narrow width", w2[0], 9);
    chk("R4", "tone1 narrow width", w2[2], 5);
    chk("R4", "tone0 narrow offset", r2[0] - r1[0], 4);
    chk("R8", "busy after drain", int'(busy), 0);
  endtask

  task automatic t_fast_to_slow();
    int acc;
    clr();
    send(2, 8'b01, acc);
    repeat (70) @(negedge clk);
    chk("R5", "bit1 first rise offset", r1[0] - acc, 2);
    chk("R2", "tone1 period", r1[1] - r1[0], 12);
    chk("R7", "tone1 held to zero", r1[2] - r1[1], 12);
    chk("R7", "spacing across 1->0 change", r1[3] - r1[2], 14);
    chk("R3", "tone0 width after change", w1[3], 17);
    chk("R4", "tone1 narrow offset", r2[0] - r1[0], 2);
  endtask

  task automatic t_bit_timing();
    int highs = 0, last = -1;
    @(negedge clk); valid = 1'b1; data = 1'b0;
    #1;
    while (!ready) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk); valid = 1'b0;
    for (int i = 0; i < 30; i++) begin
      if (i > 0) @(negedge clk);
      if (ready) begin highs = highs + 1; last = i; end
    end
    chk("R6", "ready cycles per bit", highs, 1);
    chk("R6", "ready position in bit", last, 29);
    @(negedge clk);
    chk("R8", "busy after last bit", int'(busy), 0);
    chk("R8", "wide after last bit", int'(pw), 0);
    chk("R6", "ready back when idle", int'(ready), 1);
  endtask

  task automatic t_disable();
    int acc;
    @(negedge clk); valid = 1'b1; data = 1'b0;
    #1;
    while (!ready) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk); valid = 1'b0;
    repeat (9) @(negedge clk);
    chk("R9", "wide high before disable", int'(pw), 1);
    tx_en = 1'b0;
    #1;
    chk("R9", "ready while disabled", int'(ready), 0);
    @(negedge clk);
    chk("R9", "wide after disable", int'(pw), 0);
    chk("R9", "narrow after disable", int'(pn), 0);
    chk("R9", "busy after disable", int'(busy), 0);
    repeat (5) @(negedge clk);
    tx_en = 1'b1;
    clr();
    send(1, 8'b0, acc);
    repeat (30) @(negedge clk);
    chk("R9", "restart from zero", r1[0] - acc, 4);
  endtask

  task automatic t_defaults(input logic b, input int e_first, input int e_per, input int e_wid);
    int rise0 = -1, rise1 = -1, wid = 0;
    logic prev = 1'b0;
    @(negedge clk); v1 = 1'b1; d1 = b;
    #1;
    while (!rdy1) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk); v1 = 1'b0;
    for (int k = 0; k < 3990; k++) begin
      if (k > 0) @(negedge clk);
      if (pw1 && !prev) begin
        if (rise0 < 0) rise0 = k; else if (rise1 < 0) rise1 = k;
      end
      if (pw1 && rise1 < 0) wid = wid + 1;
      prev = pw1;
    end
    repeat (20) @(negedge clk);
    chk("R3", "default first rise", rise0, e_first);
    chk("R2", "default rounded period", rise1 - rise0, e_per);
    chk("R3", "default wide width", wid, e_wid);
  endtask

  initial begin
    #1_000_000;
    fails = fails + 1; total = total + 1;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_slow_to_fast();
    t_fast_to_slow();
    t_bit_timing();
    t_disable();
    // R5: with the reversed mapping, bit 0 selects the 74 kHz tone
    t_defaults(1'b0, 225, 1352, 903);
    t_defaults(1'b1, 264, 1588, 1061);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule